// File: doc/BRIEF.md
# Register-Mapped Flash Access Controller

This block converts host accesses to a small register file into operations on a flash memory. The host sees three registers. A control register holds a write-mode nibble and a read-mode nibble. There is a 16-bit address register and an 8-bit data register. Accesses to the address and control registers only store values. A write or a read of the data register can start a flash operation, depending on the two mode nibbles. The operation can be a byte program, a page erase, an erase of the whole user area, or a byte fetch.

The flash side is a one-cycle request strobe that carries an operation code, an address and a write byte, and a done strobe that carries the fetched byte back. While an operation is outstanding the block reports busy. Any access that would start a second operation during that time is dropped. A data-valid flag tracks whether a fetched byte is waiting in the data register. One read mode uses that flag so that a single-byte read does not trigger an extra fetch.

Top module: `flash_regbridge`

## Requirements
- R1: After reset the control register reads 0x00, the address and data registers read 0x0000, and busy and data_valid are low.
- R2: With write mode 0 (control bits 7:4 = 0000), a data-register write only stores the byte and issues no flash request.
- R3: With write mode 1, a data-register write issues a program request (op code 1) carrying the current address and the written byte. The address register increments by one when the flash reports done.
- R4: With write mode 2, a data-register write of 0xA5 issues a page-erase request (op code 2). Its address is the current address with bits 8:0 cleared. Any other written value issues nothing. The address register is left unchanged.
- R5: An erase written while the address is 0x1DFE or 0x1DFF issues a user-area erase request (op code 3) at address 0x0000 instead of a page erase.
- R6: With read mode 0 (control bits 3:0 = 0000), a data-register read returns the stored byte and issues no flash request.
- R7: With read mode 1, a data-register read issues a fetch request (op code 0) at the current address when the block is not busy. On done, the fetched byte is loaded into the data register, data_valid is set and the address increments.
- R8: With read mode 2, a data-register read issues a fetch only when the block is not busy and data_valid is low.
- R9: Mode codes other than 0000, 0001 and 0010 start nothing. A data write still stores its byte.
- R10: While busy, accesses that would start an operation are ignored. A data-register write still updates the data register.
- R11: Any host read of the data register clears data_valid, unless a fetch completes in the same cycle.
- R12: fl_req is high for exactly one cycle per operation. fl_op and fl_addr hold steady while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects on data register) |
| host_wdata | input | 16 | Host write value (low byte for control and data) |
| host_rdata | output | 16 | Selected register value, zero-extended |
| busy | output | 1 | Flash operation outstanding |
| data_valid | output | 1 | Fetched byte waiting in data register |
| fl_req | output | 1 | One-cycle operation request |
| fl_op | output | 2 | 0 fetch, 1 program, 2 page erase, 3 user-area erase |
| fl_addr | output | 16 | Operation address |
| fl_wdata | output | 8 | Byte to program |
| fl_done | input | 1 | Flash completion strobe |
| fl_rdata | input | 8 | Fetched byte, valid with fl_done |

## Verification
The in-line assertions check the following on every cycle:
- the single-cycle request strobe and the operand hold while busy;
- page alignment of erase addresses;
- the data-valid set and clear rules;
- the address staying put across an erase.

Only the scenarios can show the rest:
- which mode nibble leads to which request;
- the 0xA5 key gate and the two mass-erase trigger addresses;
- read mode 2 suppressing the trailing fetch;
- accesses during busy being dropped while the data byte still updates.

A scoreboard compares every flash request against the list predicted from the register writes.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_PERASE = 2'd2,
    OP_MERASE = 2'd3
  } fl_op_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } host_sel_e;

  localparam logic [3:0] MODE_PLAIN  = 4'd0;
  localparam logic [3:0] MODE_ALWAYS = 4'd1;
  localparam logic [3:0] MODE_GATED  = 4'd2;
  localparam logic [7:0] ERASE_KEY   = 8'hA5;
endpackage

// File: rtl/fbr_regs.sv
module fbr_regs
  import fbr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          addr_wr,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [AW-1:0] wdata,
  input  logic          done_evt,
  input  fl_op_e        done_op,
  input  logic [DW-1:0] fl_rdata,
  output logic [7:0]    ctrl_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          valid_q
);
  logic [7:0]    ctrl_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] data_d;
  logic          valid_d;
  logic          rd_done;
  logic          adv_done;

  assign rd_done  = done_evt && (done_op == OP_READ);
  assign adv_done = done_evt && ((done_op == OP_READ) || (done_op == OP_PROG));

  always_comb begin
    ctrl_d  = ctrl_q;
    addr_d  = addr_q;
    data_d  = data_q;
    valid_d = valid_q;
    if (ctrl_wr) ctrl_d = wdata[7:0];
    if (addr_wr)       addr_d = wdata;
    else if (adv_done) addr_d = addr_q + AW'(1);
    if (data_wr)      data_d = wdata[DW-1:0];
    else if (rd_done) data_d = fl_rdata;
    if (rd_done)      valid_d = 1'b1;
    else if (data_rd) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  a_r11_valid_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rd_done) |=> !valid_q);

  a_r7_fetch_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !data_wr) |=> (valid_q && data_q == $past(fl_rdata)));

  a_r4_erase_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && (done_op == OP_PERASE || done_op == OP_MERASE) && !addr_wr)
      |=> $stable(addr_q));
endmodule

// File: rtl/fbr_decode.sv
module fbr_decode
  import fbr_pkg::*;
#(
  parameter int             AW        = 16,
  parameter int             DW        = 8,
  parameter int             PAGE_BITS = 9,
  parameter logic [AW-1:0]  MASS_ADDR = 16'h1DFE
) (
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [DW-1:0] wbyte,
  input  logic [7:0]    ctrl,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  input  logic          valid,
  output logic          start,
  output fl_op_e        op,
  output logic [AW-1:0] op_addr
);
  localparam logic [AW-1:0] PAGE_MASK = {{(AW-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

  logic [3:0] wmode;
  logic [3:0] rmode;
  logic       mass_hit;
  logic       want;

  assign wmode    = ctrl[7:4];
  assign rmode    = ctrl[3:0];
  assign mass_hit = (addr == MASS_ADDR) || (addr == MASS_ADDR + AW'(1));

  always_comb begin
    want    = 1'b0;
    op      = OP_READ;
    op_addr = addr;
    if (data_wr) begin
      case (wmode)
        MODE_ALWAYS: begin
          want = 1'b1;
          op   = OP_PROG;
        end
        MODE_GATED: begin
          if (wbyte == ERASE_KEY[DW-1:0]) begin
            want = 1'b1;
            if (mass_hit) begin
              op      = OP_MERASE;
              op_addr = '0;
            end else begin
              op      = OP_PERASE;
              op_addr = addr & ~PAGE_MASK;
            end
          end
        end
        default: want = 1'b0;
      endcase
    end else if (data_rd) begin
      case (rmode)
        MODE_ALWAYS: want = 1'b1;
        MODE_GATED:  want = !valid;
        default:     want = 1'b0;
      endcase
    end
  end

  assign start = want && !busy;
endmodule

// File: rtl/fbr_seq.sv
module fbr_seq
  import fbr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  fl_op_e        op,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  input  logic          fl_done,
  output logic          busy,
  output logic          fl_req,
  output fl_op_e        fl_op,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          done_evt,
  output fl_op_e        done_op
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e           st_q, st_d;
  fl_op_e        op_q, op_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          load_en;

  assign load_en = (st_q == ST_IDLE) && start;

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    if (load_en) begin
      op_d   = op;
      addr_d = op_addr;
      wd_d   = op_wdata;
    end
    case (st_q)
      ST_IDLE:  if (start) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (fl_done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_READ;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign fl_req   = (st_q == ST_ISSUE);
  assign fl_op    = op_q;
  assign fl_addr  = addr_q;
  assign fl_wdata = wd_q;
  assign done_evt = (st_q == ST_WAIT) && fl_done;
  assign done_op  = op_q;

  a_r12_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> !fl_req);

  a_r12_hold_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(fl_op) && $stable(fl_addr)));

  a_r10_req_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> fl_req);
endmodule

// File: rtl/flash_regbridge.sv
module flash_regbridge
  import fbr_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            DW        = 8,
  parameter int            PAGE_BITS = 9,
  parameter logic [15:0]   MASS_ADDR = 16'h1DFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  output logic          busy,
  output logic          data_valid,
  output logic          fl_req,
  output logic [1:0]    fl_op,
  output logic [15:0]   fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic          fl_done,
  input  logic [7:0]    fl_rdata
);
  logic          rst_meta, rst_sync;
  logic          ctrl_wr, addr_wr, data_wr, data_rd;
  logic [7:0]    ctrl_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          start;
  fl_op_e        dec_op, seq_op, done_op;
  logic [AW-1:0] dec_addr;
  logic          done_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign ctrl_wr = host_wr && (host_sel == SEL_CTRL);
  assign addr_wr = host_wr && (host_sel == SEL_ADDR);
  assign data_wr = host_wr && (host_sel == SEL_DATA);
  assign data_rd = host_rd && !host_wr && (host_sel == SEL_DATA);

  fbr_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sync),
    .ctrl_wr(ctrl_wr), .addr_wr(addr_wr), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(host_wdata), .done_evt(done_evt), .done_op(done_op), .fl_rdata(fl_rdata),
    .ctrl_q(ctrl_q), .addr_q(addr_q), .data_q(data_q), .valid_q(data_valid)
  );

  fbr_decode #(.AW(AW), .DW(DW), .PAGE_BITS(PAGE_BITS), .MASS_ADDR(MASS_ADDR)) u_dec (
    .data_wr(data_wr), .data_rd(data_rd), .wbyte(host_wdata[DW-1:0]),
    .ctrl(ctrl_q), .addr(addr_q), .busy(busy), .valid(data_valid),
    .start(start), .op(dec_op), .op_addr(dec_addr)
  );

  fbr_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_sync),
    .start(start), .op(dec_op), .op_addr(dec_addr), .op_wdata(host_wdata[DW-1:0]),
    .fl_done(fl_done), .busy(busy), .fl_req(fl_req), .fl_op(seq_op),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .done_evt(done_evt), .done_op(done_op)
  );

  assign fl_op = seq_op;

  always_comb begin
    case (host_sel)
      SEL_CTRL: host_rdata = {8'h00, ctrl_q};
      SEL_ADDR: host_rdata = addr_q;
      SEL_DATA: host_rdata = {{(16-DW){1'b0}}, data_q};
      default:  host_rdata = '0;
    endcase
  end

  a_r4_page_aligned: assert property (@(posedge clk) disable iff (!rst_sync)
    (fl_req && fl_op == OP_PERASE) |-> (fl_addr[PAGE_BITS-1:0] == '0));

  a_r5_mass_at_zero: assert property (@(posedge clk) disable iff (!rst_sync)
    (fl_req && fl_op == OP_MERASE) |-> (fl_addr == '0));
endmodule

// File: tb/tb_flash_regbridge.sv
module tb_flash_regbridge;
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } exp_t;

  logic        clk, rst_n;
  logic [1:0]  host_sel;
  logic        host_wr, host_rd;
  logic [15:0] host_wdata, host_rdata;
  logic        busy, data_valid, fl_req, fl_done;
  logic [1:0]  fl_op;
  logic [15:0] fl_addr;
  logic [7:0]  fl_wdata, fl_rdata;

  int checks = 0;
  int fails  = 0;
  exp_t exp_q[$];
  logic [7:0] mem [0:8191];

  flash_regbridge dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .data_valid(data_valid), .fl_req(fl_req), .fl_op(fl_op),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_done(fl_done), .fl_rdata(fl_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_req(input logic [1:0] op, input logic [15:0] addr, input logic [7:0] wd);
    exp_t e;
    e.op = op; e.addr = addr; e.wdata = wd;
    exp_q.push_back(e);
  endtask

  task automatic hwrite(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    host_sel = sel; host_wdata = val; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    host_sel = sel; host_rd = 1'b1;
    #1 val = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic quiet(input string req);
    repeat (8) @(negedge clk);
    check(req, 16'(exp_q.size()), 16'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && fl_req) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12: unexpected request op %0d addr %h expected none", fl_op, fl_addr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R12 op", {14'd0, fl_op}, {14'd0, e.op});
        check("R12 addr", fl_addr, e.addr);
        if (e.op == 2'd1) check("R3 wdata", {8'd0, fl_wdata}, {8'd0, e.wdata});
      end
    end
  end

  // flash model
  initial begin
    fl_done = 1'b0; fl_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n && fl_req) begin
        logic [1:0]  op;
        logic [15:0] a;
        logic [7:0]  wd;
        op = fl_op; a = fl_addr; wd = fl_wdata;
        repeat (3) @(negedge clk);
        case (op)
          2'd0: fl_rdata = mem[a[12:0]];
          2'd1: mem[a[12:0]] = wd;
          2'd2: for (int i = 0; i < 512; i++) mem[{a[12:9], 9'(i)}] = 8'hFF;
          default: for (int i = 0; i < 16'h1E00; i++) mem[i] = 8'hFF;
        endcase
        fl_done = 1'b1;
        @(negedge clk);
        fl_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 8192; i++) mem[i] = 8'(i) ^ 8'h3C;
    host_sel = 2'd0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hread(2'd0, v); check("R1 ctrl", v, 16'h0000);
    hread(2'd1, v); check("R1 addr", v, 16'h0000);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 valid", {15'd0, data_valid}, 16'd0);
    hread(2'd2, v); check("R1 data", v, 16'h0000);

    // R2 / R6 plain modes
    hwrite(2'd0, 16'h0000);
    hwrite(2'd2, 16'h005A);
    hread(2'd2, v); check("R6 data", v, 16'h005A);
    quiet("R2 no request");

    // R3 program
    hwrite(2'd0, 16'h0010);
    hwrite(2'd1, 16'h0100);
    expect_req(2'd1, 16'h0100, 8'h77);
    hwrite(2'd2, 16'h0077);
    wait_idle();
    hread(2'd1, v); check("R3 addr inc", v, 16'h0101);

    // R7 block fetch
    hwrite(2'd0, 16'h0001);
    hwrite(2'd1, 16'h0100);
    expect_req(2'd0, 16'h0100, 8'h00);
    hread(2'd2, v); check("R7 old data", v, 16'h0077);
    wait_idle();
    check("R7 valid", {15'd0, data_valid}, 16'd1);
    expect_req(2'd0, 16'h0101, 8'h00);
    hread(2'd2, v); check("R7 fetched", v, 16'h0077);
    wait_idle();
    hwrite(2'd0, 16'h0000);
    hread(2'd2, v); check("R7 fetched next", v, 16'h003D);
    check("R11 valid cleared", {15'd0, data_valid}, 16'd0);
    hread(2'd1, v); check("R7 addr", v, 16'h0102);

    // R8 gated fetch
    hwrite(2'd0, 16'h0002);
    expect_req(2'd0, 16'h0102, 8'h00);
    hread(2'd2, v); check("R8 stale", v, 16'h003D);
    wait_idle();
    check("R8 valid", {15'd0, data_valid}, 16'd1);
    hread(2'd2, v); check("R8 byte", v, 16'h003E);
    quiet("R8 no extra fetch");
    check("R11 valid low", {15'd0, data_valid}, 16'd0);
    hread(2'd1, v); check("R8 addr", v, 16'h0103);

    // R10 busy drops
    hwrite(2'd0, 16'h0001);
    expect_req(2'd0, 16'h0103, 8'h00);
    hread(2'd2, v);
    hread(2'd2, v);
    wait_idle();
    quiet("R10 busy read dropped");
    hread(2'd1, v); check("R10 addr once", v, 16'h0104);
    hwrite(2'd0, 16'h0010);
    hwrite(2'd1, 16'h0200);
    expect_req(2'd1, 16'h0200, 8'h11);
    hwrite(2'd2, 16'h0011);
    hwrite(2'd2, 16'h0022);
    hread(2'd2, v); check("R10 data updated", v, 16'h0022);
    wait_idle();
    quiet("R10 busy write dropped");
    hread(2'd1, v); check("R10 addr", v, 16'h0201);

    // R4 page erase with key
    hwrite(2'd0, 16'h0020);
    hwrite(2'd1, 16'h0345);
    hwrite(2'd2, 16'h0012);
    quiet("R4 wrong key");
    expect_req(2'd2, 16'h0200, 8'h00);
    hwrite(2'd2, 16'h00A5);
    wait_idle();
    hread(2'd1, v); check("R4 addr kept", v, 16'h0345);
    hwrite(2'd0, 16'h0001);
    hwrite(2'd1, 16'h0210);
    expect_req(2'd0, 16'h0210, 8'h00);
    hread(2'd2, v);
    wait_idle();
    hwrite(2'd0, 16'h0000);
    hread(2'd2, v); check("R4 erased", v, 16'h00FF);

    // R5 user-area erase triggers
    hwrite(2'd0, 16'h0020);
    hwrite(2'd1, 16'h1DFE);
    expect_req(2'd3, 16'h0000, 8'h00);
    hwrite(2'd2, 16'h00A5);
    wait_idle();
    hread(2'd1, v); check("R5 addr kept", v, 16'h1DFE);
    hwrite(2'd1, 16'h1DFF);
    expect_req(2'd3, 16'h0000, 8'h00);
    hwrite(2'd2, 16'h00A5);
    wait_idle();
    hwrite(2'd1, 16'h1DFD);
    expect_req(2'd2, 16'h1C00, 8'h00);
    hwrite(2'd2, 16'h00A5);
    wait_idle();

    // R9 reserved codes
    hwrite(2'd0, 16'h0033);
    hwrite(2'd2, 16'h00A5);
    hread(2'd2, v); check("R9 data stored", v, 16'h00A5);
    quiet("R9 reserved 3");
    hwrite(2'd0, 16'h00F4);
    hwrite(2'd2, 16'h0066);
    hread(2'd2, v); check("R9 data stored 2", v, 16'h0066);
    quiet("R9 reserved F/4");

    check("R12 queue drained", 16'(exp_q.size()), 16'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule